// File: doc/BRIEF.md
# Compare Timer Channel

This block is a single 16-bit timer channel. A free-running up-counter advances on every clock cycle in which the count enable is high. Four general compare registers watch that counter. Each one owns a sticky match flag. A flag goes high whenever the counter equals its register. Software reaches the counter, the four compare registers, a status register and a mode register through a simple register bus. Writes take effect on the next clock edge. Read data is presented in the same cycle.

A flag can only be cleared by a two-step exchange. Software first reads the status register and sees the flag at 1. It then writes 0 to that bit. Arming is tracked per flag. Two mode bits let the third register serve as a buffer that reloads the first register on the first register's match. They also let the fourth register reload the second register in the same way. A low-power hold input freezes counting and flag setting. Every register keeps its contents while the hold is asserted, and only the reset input initialises them.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the counter reads 0x0000, all four compare registers read 0xFFFF, all flags are 0 and the mode register reads 0.
- R2: The counter rises by one after each clock edge on which `cnt_en` is high and `lp_hold` is low. It wraps from 0xFFFF to 0x0000. A bus write to the counter (address 0) loads it instead of counting.
- R3: When the counter equals compare register k (addresses 1 to 4 hold registers 0 to 3), flag k is 1 from the next cycle. Flag k appears on `flag_o[k]` and on bit k of the status register (address 5).
- R4: A set flag stays 1 while no valid clearing write reaches it, even after the counter has moved past the match value.
- R5: A write to the status register with bit k equal to 0 clears flag k, provided the status register was read while flag k was 1. Writing 1 to a bit leaves that flag unchanged.
- R6: A clearing write has no effect on a flag that was not read as 1 beforehand. Arming is per flag: a status read arms only the flags that are 1 in that read. A clear consumes the arming.
- R7: If a match for flag k occurs in the same cycle as a valid clearing write to flag k, the flag stays 1.
- R8: Mode register (address 6) bit 0 makes register 2 the buffer of register 0, and bit 1 makes register 3 the buffer of register 1. When buffering is enabled, a match on the buffered register copies the buffer's value into it on that edge. When buffering is disabled, no copy is made.
- R9: While `lp_hold` is high the counter does not advance, no flag is set and no buffer copy occurs, and every register keeps its value. After `lp_hold` falls, an existing match sets its flag again.
- R10: Reads return the addressed register in the same cycle: counter, registers 0 to 3, status in bits 3:0, mode in bits 1:0. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| lp_hold | input | 1 | Low-power hold: freezes counting and flag setting |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing on status reads) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| flag_o | output | 4 | Match flags, bit k for compare register k |

## Verification
A corrupted counter shows up at address 0 on the very next cycle. It also shows up as a flag that rises at the wrong count, one cycle after the bad comparison. A wrong arming bit stays invisible until software tries to clear. It then appears as a flag that survives a legal clear or falls on an illegal one, one cycle after the write. A bad buffer copy shows up in the buffered register on the cycle after its match. A bad hold path shows up as a counter that moves, or a flag that rises, while the hold is asserted.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int NCMP = 4;
  localparam int AW   = 3;

  localparam logic [AW-1:0] A_CNT  = 3'd0;
  localparam logic [AW-1:0] A_CMP0 = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd5;
  localparam logic [AW-1:0] A_MODE = 3'd6;

  typedef logic [NCMP-1:0] flag_vec_t;

  // bus address of compare register i
  function automatic logic [AW-1:0] cmp_addr(input int i);
    return A_CMP0 + AW'(i);
  endfunction

  // new flag value: a match always wins over a clear
  function automatic flag_vec_t flag_next(input flag_vec_t cur,
                                          input flag_vec_t hit,
                                          input flag_vec_t clr);
    return (cur & ~clr) | hit;
  endfunction

  // clearing permission: gained on a read that sees 1, lost on a clear
  function automatic flag_vec_t arm_next(input flag_vec_t arm,
                                         input logic      rd_stat,
                                         input flag_vec_t cur,
                                         input flag_vec_t clr);
    return (arm | ({NCMP{rd_stat}} & cur)) & ~clr;
  endfunction
endpackage

// File: rtl/ctc_counter.sv
module ctc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ctc_cmp_bank.sv
module ctc_cmp_bank #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        cnt,
  input  logic                hold,
  input  logic [N-1:0]        wr_sel,
  input  logic [W-1:0]        wdata,
  input  logic [N/2-1:0]      buf_en,
  output logic [N-1:0][W-1:0] cmp_o,
  output logic [N-1:0]        match_o
);
  localparam int HALF = N / 2;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] r;
    logic         xfer;

    if (i < HALF) begin : g_buffered
      assign xfer = buf_en[i] & match_o[i];
    end else begin : g_plain
      assign xfer = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         r <= '1;
      else if (wr_sel[i]) r <= wdata;
      else if (xfer)      r <= cmp_o[(i + HALF) % N];
    end

    assign cmp_o[i]   = r;
    assign match_o[i] = ~hold & (cnt == r);
  end
endmodule

// File: rtl/ctc_flags.sv
module ctc_flags
  import ctc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t hit,
  input  logic      rd_stat,
  input  logic      wr_stat,
  input  flag_vec_t wbits,
  output flag_vec_t flag,
  output flag_vec_t clr_hit
);
  flag_vec_t armed;

  assign clr_hit = {NCMP{wr_stat}} & ~wbits & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= '0;
      armed <= '0;
    end else begin
      flag  <= flag_next(flag, hit, clr_hit);
      armed <= arm_next(armed, rd_stat, flag, clr_hit);
    end
  end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import ctc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             lp_hold,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [NCMP-1:0]  flag_o
);
  localparam int NBUF = NCMP / 2;

  logic                        cnt_ld;
  logic                        cnt_step;
  logic [CNT_W-1:0]            cnt_q;
  logic [NCMP-1:0]             wr_cmp;
  logic [NCMP-1:0][CNT_W-1:0]  cmp_q;
  flag_vec_t                   match;
  flag_vec_t                   flag;
  flag_vec_t                   clr_hit;
  logic [NBUF-1:0]             mode_q;
  logic                        rd_stat;
  logic                        wr_stat;

  assign cnt_ld   = bus_wr & (bus_addr == A_CNT);
  assign cnt_step = cnt_en & ~lp_hold;
  assign rd_stat  = bus_rd & (bus_addr == A_STAT);
  assign wr_stat  = bus_wr & (bus_addr == A_STAT);

  for (genvar i = 0; i < NCMP; i++) begin : g_dec
    assign wr_cmp[i] = bus_wr & (bus_addr == cmp_addr(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           mode_q <= '0;
    else if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata[NBUF-1:0];
  end

  ctc_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (cnt_step),
    .ld     (cnt_ld),
    .ld_val (bus_wdata),
    .cnt    (cnt_q)
  );

  ctc_cmp_bank #(.W(CNT_W), .N(NCMP)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .hold    (lp_hold),
    .wr_sel  (wr_cmp),
    .wdata   (bus_wdata),
    .buf_en  (mode_q),
    .cmp_o   (cmp_q),
    .match_o (match)
  );

  ctc_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (match),
    .rd_stat (rd_stat),
    .wr_stat (wr_stat),
    .wbits   (bus_wdata[NCMP-1:0]),
    .flag    (flag),
    .clr_hit (clr_hit)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT:  bus_rdata = cnt_q;
      A_STAT: bus_rdata = CNT_W'(flag);
      A_MODE: bus_rdata = CNT_W'(mode_q);
      default: begin
        for (int i = 0; i < NCMP; i++)
          if (bus_addr == cmp_addr(i)) bus_rdata = cmp_q[i];
      end
    endcase
  end

  assign flag_o = flag;
endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk #(
  parameter int W = 16,
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         lp_hold,
  input logic         cnt_ld,
  input logic [W-1:0] cnt_q,
  input logic [N-1:0] match,
  input logic [N-1:0] flag,
  input logic [N-1:0] clr_hit
);
  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !lp_hold && !cnt_ld) |=> cnt_q == W'($past(cnt_q) + 1'b1));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_hold && !cnt_ld) |=> $stable(cnt_q));

  for (genvar i = 0; i < N; i++) begin : g_f
    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(match[i]));

    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(clr_hit[i]));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |=> flag[i]);

    // R9
    hold_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_hold && !flag[i]) |=> !flag[i]);
  end
endmodule

bind cmp_timer_chan cmp_timer_chan_chk #(.W(CNT_W), .N(ctc_pkg::NCMP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .lp_hold (lp_hold),
  .cnt_ld  (cnt_ld),
  .cnt_q   (cnt_q),
  .match   (match),
  .flag    (flag),
  .clr_hit (clr_hit)
);

// File: tb/cmp_timer_chan_bench.sv
`timescale 1ns/1ps
module cmp_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        lp_hold = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [3:0]  flag_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_timer_chan u_cmp_timer_chan (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .lp_hold(lp_hold),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_o(flag_o)
  );

  // behavioural reference
  int m_cnt;
  int m_reg[4];
  bit m_flag[4];
  bit m_arm[4];
  int m_mode;

  function automatic int m_read(input int a);
    int v;
    v = 0;
    case (a)
      0: v = m_cnt;
      1, 2, 3, 4: v = m_reg[a-1];
      5: for (int k = 0; k < 4; k++) v += m_flag[k] << k;
      6: v = m_mode;
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_mode = 0;
      for (int k = 0; k < 4; k++) begin
        m_reg[k] = 'hFFFF; m_flag[k] = 0; m_arm[k] = 0;
      end
    end else begin
      bit hit[4];
      bit clr[4];
      int nreg[4];
      for (int k = 0; k < 4; k++) begin
        hit[k] = !lp_hold && (m_cnt == m_reg[k]);
        clr[k] = bus_wr && bus_addr == 5 && !bus_wdata[k] && m_arm[k];
        nreg[k] = m_reg[k];
      end
      for (int k = 0; k < 2; k++)
        if (((m_mode >> k) & 1) == 1 && hit[k]) nreg[k] = m_reg[k+2];
      for (int k = 0; k < 4; k++)
        if (bus_wr && bus_addr == k + 1) nreg[k] = bus_wdata;
      for (int k = 0; k < 4; k++) begin
        if (clr[k]) m_arm[k] = 0;
        else if (bus_rd && bus_addr == 5 && m_flag[k]) m_arm[k] = 1;
        if (hit[k]) m_flag[k] = 1;
        else if (clr[k]) m_flag[k] = 0;
        m_reg[k] = nreg[k];
      end
      if (bus_wr && bus_addr == 0) m_cnt = bus_wdata;
      else if (cnt_en && !lp_hold) m_cnt = (m_cnt + 1) % 65536;
      if (bus_wr && bus_addr == 6) m_mode = bus_wdata & 3;
    end
  end

  // per-cycle comparison, away from both edges
  always begin
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      int ef;
      ef = m_read(5);
      n_cmp++;
      if (flag_o !== 4'(ef)) begin
        n_bad++;
        $display("FAIL R3 per-cycle flag_o=%h expected %h", flag_o, ef);
      end
      n_cmp++;
      if (bus_rdata !== 16'(m_read(bus_addr))) begin
        n_bad++;
        $display("FAIL R10 per-cycle addr %0d rdata=%h expected %h",
                 bus_addr, bus_rdata, m_read(bus_addr));
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_stat(output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'd5;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a);
    #2 d = bus_rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    peek(0, v); check("R1 counter", v, 0);
    for (int k = 1; k <= 4; k++) begin
      peek(k, v); check("R1 compare", v, 'hFFFF);
    end
    peek(5, v); check("R1 status", v, 0);
    peek(6, v); check("R1 mode", v, 0);
    // R10 unused address
    peek(7, v); check("R10 addr7", v, 0);

    // R2 wrap; R3 all four registers at 0xFFFF match
    wr(0, 'hFFFE);
    run(2);
    peek(0, v); check("R2 wrap", v, 0);
    check("R3 flags after FFFF", flag_o, 'hF);
    idle(4);
    check("R4 flags sticky", flag_o, 'hF);

    // R6 clear write without a prior read
    wr(5, 0); idle(1);
    check("R6 unarmed clear", flag_o, 'hF);

    // R5 read then clear bits 0 and 2, bits written 1 untouched
    rd_stat(v); check("R5 status read", v, 'hF);
    wr(5, 'h000A); idle(1);
    check("R5 selective clear", flag_o, 'hA);
    wr(5, 0); idle(1);
    check("R5 remaining armed flags", flag_o, 0);

    // R6 read while flag 0 does not arm it
    rd_stat(v);
    wr(1, 5); wr(0, 5); wr(0, 'h40);
    check("R3 flag 0 set", flag_o, 1);
    wr(5, 0); idle(1);
    check("R6 per-flag arming", flag_o, 1);

    // R7 coincident match and valid clear
    wr(0, 5);
    rd_stat(v);
    wr(5, 0); idle(1);
    check("R7 set wins", flag_o, 1);
    wr(0, 'h200);
    rd_stat(v);
    wr(5, 0); idle(1);
    check("R5 clear after move", flag_o, 0);

    // R8 buffer 2 -> 0 enabled, 3 -> 1 disabled
    wr(6, 1);
    peek(6, v); check("R10 mode readback", v, 1);
    wr(1, 'h210); wr(3, 'h300); wr(0, 'h20E);
    run(3);
    peek(1, v); check("R8 buffer copy", v, 'h300);
    check("R8 flag on buffered match", flag_o, 1);
    peek(2, v); check("R8 pair untouched", v, 'hFFFF);
    wr(2, 'h220); wr(4, 'h400);
    run(16);
    peek(2, v); check("R8 no copy when disabled", v, 'h220);
    check("R8 flag 1", flag_o, 3);

    // R9 low-power hold
    wr(1, 'h230);
    @(negedge clk) lp_hold = 1'b1;
    run(20);
    peek(0, v); check("R9 counter frozen", v, 'h221);
    wr(0, 'h300);
    idle(3);
    check("R9 no flag in hold", flag_o, 3);
    peek(1, v); check("R9 register kept", v, 'h230);
    @(negedge clk) lp_hold = 1'b0;
    idle(2);
    check("R9 flag after release", flag_o, 7);

    idle(2);
    finish_run();
  end
endmodule